// File: doc/BRIEF.md
# Slave-Port Bus Arbiter

This unit decides which of several bus masters may drive one slave port of a multi-master interconnect. Each master raises a request line; the unit answers with a registered one-hot grant and a `connected` flag that tells the datapath whether the granted path was already in place in the previous cycle. When a master is newly connected, `connected` stays low for one cycle. That cycle is the reconnect bubble, and the datapath lets the access proceed only once the flag is high.

Four configuration inputs shape the behaviour. One input selects rotating or fixed-priority selection. A two-bit input sets what the port does when it goes quiet: drop every master, stay with the most recent one, or move to a programmed master. A parking index names that programmed master. A beat budget limits how long a burst may run before a waiting master may take the slave. The slave datapath reports the end of each beat and whether that beat closes the burst. The arbiter changes its decision only at those points, or when the holding master withdraws its request.

Top module: `slave_port_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `grant` all zero and `connected` low.
- R2: With `cfg_arb_prio` = 1, the lowest-numbered requesting master wins a free arbitration.
- R3: With `cfg_arb_prio` = 0, a free arbitration searches upward (wrapping) from the master after the one granted most recently. After reset the search begins at master 0.
- R4: In the first cycle a master holds a grant it did not hold before, `connected` is low. In every later cycle of an unchanged non-zero grant, `connected` is high.
- R5: Once a master holds the slave, other requests do not move the grant while that master still requests, unless a beat that closes its burst ends (`beat_done` and `burst_last` in a connected cycle) or R10 applies.
- R6: With `cfg_park_mode` = 0 (and likewise 3), a cycle with no request from any master is followed by an all-zero grant. A finished burst with no other requester also leaves the grant at zero.
- R7: With `cfg_park_mode` = 1, when nobody else requests, the grant stays on the master that used the slave last and `connected` stays high. A new single access from that master completes without a bubble.
- R8: With `cfg_park_mode` = 2, an idle port moves its grant to the master named by `cfg_park_idx`. `connected` follows one cycle later, and that master's next access needs no bubble.
- R9: If `cfg_park_idx` names a master without a path to this slave (bit clear in `PATH_MASK`), mode 2 behaves exactly as mode 0.
- R10: With a non-zero `cfg_slot_limit` of L, a beat that ends in the L-th or a later connected cycle of a burst and does not close it hands the slave to another requesting master. The interrupted master is excluded from that arbitration.
- R11: If the beat budget is used up but no other master requests, the burst keeps the slave.
- R12: `cfg_slot_limit` = 0 disables the budget: bursts are never interrupted.
- R13: `grant` has at most one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_arb_prio | input | 1 | 0 rotating selection, 1 fixed priority (master 0 highest) |
| cfg_park_mode | input | 2 | 0 no parking, 1 park on last user, 2 park on indexed master, 3 as 0 |
| cfg_park_idx | input | IW | Master parked on in mode 2 (IW = log2 of master count) |
| cfg_slot_limit | input | SLOT_W | Burst beat budget in connected cycles, 0 = unlimited |
| req | input | N_MASTERS | Per-master request, held until the master's final beat |
| beat_done | input | 1 | The current beat on the slave ends this cycle |
| burst_last | input | 1 | The ending beat is the last of its burst |
| grant | output | N_MASTERS | One-hot grant, or zero when no master is attached |
| connected | output | 1 | Grant unchanged from the previous cycle, so the access may proceed |

## Verification
A table of single-cycle stimuli runs the core selection under several request patterns. Overlapping requests under rotating order show that the search pointer advances past the latest winner. The same overlaps under fixed priority show that master 0 always wins. The table then covers each parking mode, including a parking index with no path and the reserved mode code, in sequences that separate parking from an active grant. Runs of non-final beats with and without a competing requester, under a small budget and under a zero budget, show when a burst is broken and when it continues, including a break of the highest-priority master. A reset in mid-burst closes the run.

// File: rtl/spa_pkg.sv
package spa_pkg;

    // Arbitration scheme selector
    typedef enum logic {
        ARB_ROTATE   = 1'b0,
        ARB_PRIORITY = 1'b1
    } arb_kind_e;

    // Idle-port policy selector
    typedef enum logic [1:0] {
        PARK_OFF   = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_SPARE = 2'd3
    } park_kind_e;

    // Per-cycle transfer events seen by the owner tracker
    typedef struct packed {
        logic boundary;  // connected beat ended this cycle
        logic finish;    // that beat closed the burst
        logic preempt;   // budget spent, another master waits
        logic keep;      // current owner retains the slave
    } xfer_evt_t;

    // Index width for a master count (at least one bit)
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/spa_pick.sv
module spa_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] rr_last,
    input  logic          use_prio,
    output logic          found,
    output logic [IW-1:0] win
);
    logic          prio_found, rot_found;
    logic [IW-1:0] prio_win,   rot_win;

    // Fixed priority: lowest index first
    always_comb begin
        prio_found = 1'b0;
        prio_win   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (!prio_found && cand[i]) begin
                prio_found = 1'b1;
                prio_win   = IW'(i);
            end
        end
    end

    // Rotating: search starts just after the previous winner
    always_comb begin
        rot_found = 1'b0;
        rot_win   = '0;
        for (int k = 1; k <= int'(N); k++) begin
            int j;
            j = (int'(rr_last) + k) % int'(N);
            if (!rot_found && cand[j]) begin
                rot_found = 1'b1;
                rot_win   = IW'(j);
            end
        end
    end

    always_comb begin
        if (spa_pkg::arb_kind_e'(use_prio) == spa_pkg::ARB_PRIORITY) begin
            found = prio_found;
            win   = prio_win;
        end else begin
            found = rot_found;
            win   = rot_win;
        end
    end

endmodule

// File: rtl/spa_slot.sv
module spa_slot #(
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    input  logic [SW-1:0] limit,
    output logic          expired
);
    localparam logic [SW-1:0] CNT_MAX  = '1;
    localparam logic [SW-1:0] CNT_STEP = SW'(1);
    localparam logic [SW:0]   WIDE_ONE = (SW+1)'(1);

    logic [SW-1:0] cnt_q;
    logic [SW:0]   used_now;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (advance && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_STEP;
        end
    end

    // Connected cycles of this burst including the present one
    assign used_now = {1'b0, cnt_q} + WIDE_ONE;
    assign expired  = (limit != '0) && (used_now >= {1'b0, limit});

endmodule

// File: rtl/spa_park.sv
module spa_park #(
    parameter int unsigned N              = 4,
    parameter int unsigned IW             = 2,
    parameter logic [N-1:0] PATH_MASK     = '1
) (
    input  logic [1:0]    mode,
    input  logic [IW-1:0] fixed_idx,
    input  logic          own_vld,
    input  logic [IW-1:0] own_idx,
    output logic          park_vld,
    output logic [IW-1:0] park_idx
);
    logic fixed_reach;

    // A fixed index outside the master range or without a path is unusable
    always_comb begin
        fixed_reach = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (fixed_idx == IW'(i)) begin
                fixed_reach = PATH_MASK[i];
            end
        end
    end

    always_comb begin
        park_vld = 1'b0;
        park_idx = '0;
        case (spa_pkg::park_kind_e'(mode))
            spa_pkg::PARK_LAST: begin
                park_vld = own_vld;
                park_idx = own_idx;
            end
            spa_pkg::PARK_FIXED: begin
                park_vld = fixed_reach;
                park_idx = fixed_idx;
            end
            default: begin
                park_vld = 1'b0;
                park_idx = '0;
            end
        endcase
    end

endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter #(
    parameter int unsigned  N_MASTERS = 4,
    parameter int unsigned  SLOT_W    = 8,
    parameter logic [N_MASTERS-1:0] PATH_MASK = '1,
    localparam int unsigned IW        = spa_pkg::idx_bits(N_MASTERS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_arb_prio,
    input  logic [1:0]           cfg_park_mode,
    input  logic [IW-1:0]        cfg_park_idx,
    input  logic [SLOT_W-1:0]    cfg_slot_limit,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 beat_done,
    input  logic                 burst_last,
    output logic [N_MASTERS-1:0] grant,
    output logic                 connected
);
    import spa_pkg::*;

    localparam logic [IW-1:0] RR_START = IW'(N_MASTERS - 1);

    // Registered owner state
    logic [IW-1:0]        own_q, rr_q;
    logic                 own_vld_q, lock_q, conn_q;

    // Next-state and helpers
    logic [IW-1:0]        nxt_idx, win_idx, park_idx;
    logic                 nxt_vld, nxt_lock, conn_d;
    logic                 found, park_vld, slot_exp;
    logic                 own_req, proceed;
    logic [N_MASTERS-1:0] req_eff, own_oh, cand, others;
    xfer_evt_t            evt;

    // Masters without a path to this slave are never considered
    assign req_eff = req & PATH_MASK;

    always_comb begin
        for (int i = 0; i < int'(N_MASTERS); i++) begin
            own_oh[i] = own_vld_q && (own_q == IW'(i));
        end
    end

    assign own_req = |(own_oh & req_eff);
    assign proceed = conn_q && own_req;
    assign others  = req_eff & ~own_oh;

    // Transfer events
    always_comb begin
        evt.boundary = proceed && beat_done;
        evt.finish   = evt.boundary && burst_last;
        evt.preempt  = evt.boundary && !burst_last && lock_q && slot_exp && (|others);
        evt.keep     = own_req && (lock_q || conn_q) && !evt.finish && !evt.preempt;
    end

    // At a boundary the leaving owner yields to everyone else
    assign cand = evt.boundary ? others : req_eff;

    spa_pick #(
        .N  (N_MASTERS),
        .IW (IW)
    ) u_pick (
        .cand     (cand),
        .rr_last  (rr_q),
        .use_prio (cfg_arb_prio),
        .found    (found),
        .win      (win_idx)
    );

    spa_park #(
        .N         (N_MASTERS),
        .IW        (IW),
        .PATH_MASK (PATH_MASK)
    ) u_park (
        .mode      (cfg_park_mode),
        .fixed_idx (cfg_park_idx),
        .own_vld   (own_vld_q),
        .own_idx   (own_q),
        .park_vld  (park_vld),
        .park_idx  (park_idx)
    );

    spa_slot #(
        .SW (SLOT_W)
    ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .restart (!evt.keep),
        .advance (proceed),
        .limit   (cfg_slot_limit),
        .expired (slot_exp)
    );

    // Owner selection: keep, arbitrate, or park
    always_comb begin
        if (evt.keep) begin
            nxt_vld  = 1'b1;
            nxt_idx  = own_q;
            nxt_lock = 1'b1;
        end else if (found) begin
            nxt_vld  = 1'b1;
            nxt_idx  = win_idx;
            nxt_lock = 1'b1;
        end else begin
            nxt_vld  = park_vld;
            nxt_idx  = park_idx;
            nxt_lock = 1'b0;
        end
    end

    assign conn_d = nxt_vld && own_vld_q && (nxt_idx == own_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q     <= '0;
            own_vld_q <= 1'b0;
            lock_q    <= 1'b0;
            conn_q    <= 1'b0;
            rr_q      <= RR_START;
        end else begin
            own_q     <= nxt_idx;
            own_vld_q <= nxt_vld;
            lock_q    <= nxt_lock;
            conn_q    <= conn_d;
            if (nxt_lock) begin
                rr_q <= nxt_idx;
            end
        end
    end

    assign grant     = own_oh;
    assign connected = conn_q;

endmodule

// File: rtl/spa_checker.sv
module spa_checker #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   cfg_park_mode,
    input logic [N-1:0] req,
    input logic         beat_done,
    input logic         burst_last,
    input logic [N-1:0] grant,
    input logic         connected
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (grant == '0 && !connected));

    assert_grant_onehot_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_new_grant_bubble_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(grant) |-> !connected);

    assert_connected_needs_grant_R4: assert property (@(posedge clk) disable iff (rst)
        connected |-> (grant != '0));

    assert_hold_mid_beat_R5: assert property (@(posedge clk) disable iff (rst)
        (connected && (|(grant & req)) && !beat_done) |=> $stable(grant));

    assert_no_park_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_park_mode == 2'd0 && req == '0) |=> (grant == '0));

    assert_budget_alone_R11: assert property (@(posedge clk) disable iff (rst)
        (connected && (|(grant & req)) && beat_done && !burst_last && ((req & ~grant) == '0))
        |=> $stable(grant));

endmodule

bind slave_port_arbiter spa_checker #(.N(N_MASTERS)) u_spa_checker (
    .clk           (clk),
    .rst           (rst),
    .cfg_park_mode (cfg_park_mode),
    .req           (req),
    .beat_done     (beat_done),
    .burst_last    (burst_last),
    .grant         (grant),
    .connected     (connected)
);

// File: tb/sim_slave_port_arbiter.sv
module sim_slave_port_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_arb_prio = 1'b0;
    logic [1:0] cfg_park_mode = 2'd0;
    logic [1:0] cfg_park_idx = 2'd0;
    logic [7:0] cfg_slot_limit = 8'd16;
    logic [3:0] req = 4'b0000;
    logic       beat_done = 1'b0;
    logic       burst_last = 1'b0;
    logic [3:0] grant;
    logic       connected;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    slave_port_arbiter #(
        .N_MASTERS (4),
        .SLOT_W    (8),
        .PATH_MASK (4'b0111)
    ) u0 (
        .clk            (clk),
        .rst            (rst),
        .cfg_arb_prio   (cfg_arb_prio),
        .cfg_park_mode  (cfg_park_mode),
        .cfg_park_idx   (cfg_park_idx),
        .cfg_slot_limit (cfg_slot_limit),
        .req            (req),
        .beat_done      (beat_done),
        .burst_last     (burst_last),
        .grant          (grant),
        .connected      (connected)
    );

    // Vector: prio, park mode, park idx, budget, req, beat_done, burst_last,
    //         expected grant, expected connected, requirement number
    function automatic logic [27:0] mk(input logic p, input logic [1:0] pm, input logic [1:0] pi,
                                       input logic [7:0] sl, input logic [3:0] rq, input logic bd,
                                       input logic bl, input logic [3:0] eg, input logic ec,
                                       input logic [3:0] tg);
        return {p, pm, pi, sl, rq, bd, bl, eg, ec, tg};
    endfunction

    localparam int NV = 60;
    localparam logic [27:0] VEC [NV] = '{
        // rotating, no parking, no budget
        mk(1'b0,2'd0,2'd0,8'd0,4'b0000,1'b0,1'b0,4'b0000,1'b0,4'd6),  // R6 idle
        mk(1'b0,2'd0,2'd0,8'd0,4'b0110,1'b0,1'b0,4'b0010,1'b0,4'd3),  // R3 first pick
        mk(1'b0,2'd0,2'd0,8'd0,4'b0110,1'b0,1'b0,4'b0010,1'b1,4'd4),  // R4
        mk(1'b0,2'd0,2'd0,8'd0,4'b0110,1'b1,1'b0,4'b0010,1'b1,4'd5),  // R5 mid-burst
        mk(1'b0,2'd0,2'd0,8'd0,4'b0110,1'b1,1'b1,4'b0100,1'b0,4'd3),  // R3 rotate
        mk(1'b0,2'd0,2'd0,8'd0,4'b0111,1'b0,1'b0,4'b0100,1'b1,4'd4),
        mk(1'b0,2'd0,2'd0,8'd0,4'b0111,1'b1,1'b1,4'b0001,1'b0,4'd3),  // R3 wrap
        mk(1'b0,2'd0,2'd0,8'd0,4'b0011,1'b0,1'b0,4'b0001,1'b1,4'd4),
        mk(1'b0,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b1,4'b0010,1'b0,4'd3),
        mk(1'b0,2'd0,2'd0,8'd0,4'b0010,1'b0,1'b0,4'b0010,1'b1,4'd4),
        mk(1'b0,2'd0,2'd0,8'd0,4'b0010,1'b1,1'b1,4'b0000,1'b0,4'd6),  // R6 release
        mk(1'b0,2'd0,2'd0,8'd0,4'b0000,1'b0,1'b0,4'b0000,1'b0,4'd6),
        // fixed priority
        mk(1'b1,2'd0,2'd0,8'd0,4'b0110,1'b0,1'b0,4'b0010,1'b0,4'd2),  // R2
        mk(1'b1,2'd0,2'd0,8'd0,4'b0111,1'b0,1'b0,4'b0010,1'b1,4'd5),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0111,1'b1,1'b1,4'b0001,1'b0,4'd2),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0101,1'b0,1'b0,4'b0001,1'b1,4'd4),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0101,1'b1,1'b1,4'b0100,1'b0,4'd2),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0100,1'b0,1'b0,4'b0100,1'b1,4'd4),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0100,1'b1,1'b1,4'b0000,1'b0,4'd6),
        // park on last user
        mk(1'b1,2'd1,2'd0,8'd0,4'b0010,1'b0,1'b0,4'b0010,1'b0,4'd2),
        mk(1'b1,2'd1,2'd0,8'd0,4'b0010,1'b0,1'b0,4'b0010,1'b1,4'd4),
        mk(1'b1,2'd1,2'd0,8'd0,4'b0010,1'b1,1'b1,4'b0010,1'b1,4'd7),  // R7
        mk(1'b1,2'd1,2'd0,8'd0,4'b0000,1'b0,1'b0,4'b0010,1'b1,4'd7),  // R7 idle
        mk(1'b1,2'd1,2'd0,8'd0,4'b0010,1'b1,1'b1,4'b0010,1'b1,4'd7),  // R7 no bubble
        mk(1'b1,2'd1,2'd0,8'd0,4'b0100,1'b0,1'b0,4'b0100,1'b0,4'd4),
        mk(1'b1,2'd1,2'd0,8'd0,4'b0100,1'b0,1'b0,4'b0100,1'b1,4'd4),
        mk(1'b1,2'd1,2'd0,8'd0,4'b0100,1'b1,1'b1,4'b0100,1'b1,4'd7),
        mk(1'b1,2'd1,2'd0,8'd0,4'b0000,1'b0,1'b0,4'b0100,1'b1,4'd7),
        // park on indexed master
        mk(1'b1,2'd2,2'd1,8'd0,4'b0000,1'b0,1'b0,4'b0010,1'b0,4'd8),  // R8 move
        mk(1'b1,2'd2,2'd1,8'd0,4'b0000,1'b0,1'b0,4'b0010,1'b1,4'd8),
        mk(1'b1,2'd2,2'd1,8'd0,4'b0010,1'b1,1'b1,4'b0010,1'b1,4'd8),  // R8 no bubble
        mk(1'b1,2'd2,2'd1,8'd0,4'b0100,1'b0,1'b0,4'b0100,1'b0,4'd4),
        mk(1'b1,2'd2,2'd1,8'd0,4'b0100,1'b0,1'b0,4'b0100,1'b1,4'd4),
        mk(1'b1,2'd2,2'd1,8'd0,4'b0100,1'b1,1'b1,4'b0010,1'b0,4'd8),
        // index without a path, then the reserved mode
        mk(1'b1,2'd2,2'd3,8'd0,4'b0000,1'b0,1'b0,4'b0000,1'b0,4'd9),  // R9
        mk(1'b1,2'd2,2'd3,8'd0,4'b0000,1'b0,1'b0,4'b0000,1'b0,4'd9),
        mk(1'b1,2'd3,2'd1,8'd0,4'b0000,1'b0,1'b0,4'b0000,1'b0,4'd6),
        // budget of three beats, fixed priority
        mk(1'b1,2'd0,2'd0,8'd3,4'b0001,1'b0,1'b0,4'b0001,1'b0,4'd2),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0001,1'b0,1'b0,4'b0001,1'b1,4'd4),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0101,1'b1,1'b0,4'b0001,1'b1,4'd10), // R10 beat 1
        mk(1'b1,2'd0,2'd0,8'd3,4'b0101,1'b1,1'b0,4'b0001,1'b1,4'd10), // beat 2
        mk(1'b1,2'd0,2'd0,8'd3,4'b0101,1'b1,1'b0,4'b0100,1'b0,4'd10), // beat 3 breaks
        mk(1'b1,2'd0,2'd0,8'd3,4'b0101,1'b0,1'b0,4'b0100,1'b1,4'd5),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0101,1'b1,1'b1,4'b0001,1'b0,4'd2),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0001,1'b0,1'b0,4'b0001,1'b1,4'd4),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0001,1'b1,1'b0,4'b0001,1'b1,4'd11),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0001,1'b1,1'b0,4'b0001,1'b1,4'd11),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0001,1'b1,1'b0,4'b0001,1'b1,4'd11), // R11 spent, alone
        mk(1'b1,2'd0,2'd0,8'd3,4'b0011,1'b1,1'b0,4'b0010,1'b0,4'd10), // R10 late break
        mk(1'b1,2'd0,2'd0,8'd3,4'b0011,1'b0,1'b0,4'b0010,1'b1,4'd4),
        mk(1'b1,2'd0,2'd0,8'd3,4'b0010,1'b1,1'b1,4'b0000,1'b0,4'd6),
        // budget disabled
        mk(1'b1,2'd0,2'd0,8'd0,4'b0001,1'b0,1'b0,4'b0001,1'b0,4'd2),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0001,1'b0,1'b0,4'b0001,1'b1,4'd4),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b0,4'b0001,1'b1,4'd12), // R12
        mk(1'b1,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b0,4'b0001,1'b1,4'd12),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b0,4'b0001,1'b1,4'd12),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b0,4'b0001,1'b1,4'd12),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b0,4'b0001,1'b1,4'd12),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0011,1'b1,1'b1,4'b0010,1'b0,4'd2),
        mk(1'b1,2'd0,2'd0,8'd0,4'b0000,1'b0,1'b0,4'b0000,1'b0,4'd6)
    };

    task automatic check(input logic [3:0] eg, input logic ec, input int tg);
        tests++;
        if (grant !== eg || connected !== ec) begin
            fails++;
            $display("FAIL R%0d: grant=%b connected=%b, expected grant=%b connected=%b",
                     tg, grant, connected, eg, ec);
        end
    endtask

    task automatic check_onehot_r13();
        tests++;
        if ($countones(grant) > 1) begin
            fails++;
            $display("FAIL R13: grant=%b, expected at most one bit set", grant);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(4'b0000, 1'b0, 1);                 // R1 during reset
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [27:0] e;
            e = VEC[v];
            cfg_arb_prio   = e[27];
            cfg_park_mode  = e[26:25];
            cfg_park_idx   = e[24:23];
            cfg_slot_limit = e[22:15];
            req            = e[14:11];
            beat_done      = e[10];
            burst_last     = e[9];
            @(posedge clk);
            @(negedge clk);
            check(e[8:5], e[4], int'(e[3:0]));
            check_onehot_r13();
        end

        // R1: reset in the middle of a held burst under last-user parking
        cfg_park_mode = 2'd1;
        req = 4'b0001;
        beat_done = 1'b0;
        burst_last = 1'b0;
        repeat (2) @(negedge clk);
        check(4'b0001, 1'b1, 4);
        rst = 1'b1;
        @(negedge clk);
        check(4'b0000, 1'b0, 1);                 // R1 after mid-burst reset
        rst = 1'b0;
        req = 4'b0000;
        @(negedge clk);
        check(4'b0000, 1'b0, 1);                 // R1 no stale parking

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run still active, expected completion");
            summary();
            $finish;
        end
    end

endmodule